// File: doc/BRIEF.md
# Passive Serial Configuration Sequencer

This block loads a target FPGA through a passive serial configuration port. On a start request it pulls the target's active-low configuration-request line low for a minimum pulse. It then checks that the target's active-low status line shows reset. After releasing the request it polls the status line on a coarse interval until the target signals that it is ready, and waits a setup delay. Only then does it start clocking data. All of these delays are counted in microseconds from a clock-divider tick.

Bitstream bytes arrive on a valid/ready stream. Each byte goes out serially, bit 0 first, on a data line with a generated clock that idles low. When the source has already bit-reversed the bytes, a per-job flag undoes the reversal. After the last byte the block checks the status line and, if the board wires it, the config-done line. It then clocks one byte of zeros so the target gets the trailing edges it needs to enter user mode. The job ends with a one-cycle end pulse and an error code that stays valid until the next start.

Timing differs between a standard mode and a larger-device mode: the status timeout is 1506 µs or 3000 µs and the setup delay is 2 µs or 10 µs. A start flagged as a partial reconfiguration is refused.

Top module: `ps_cfg_seq`

## Requirements
- R1: After reset, cfg_n_o=1, sck_o=0, busy_o=0, byte_ready_o=0, end_o=0 and err_o=0.
- R2: A start_i with partial_i=1 in idle gives err_o=5 and a one-cycle end_o on the next cycle. busy_o stays 0, cfg_n_o stays 1 and no sck_o edge occurs.
- R3: An accepted start drives cfg_n_o low for T_PULSE_US microseconds (2 µs by default), within a few clock cycles.
- R4: If status_n_i is not low at the end of the pulse, the job ends with err_o=1 and cfg_n_o=1, and no serial clock is sent.
- R5: After cfg_n_o rises, status_n_i is polled every T_POLL_US (268 µs). The poll limit is ceil(timeout/poll): 6 polls for a 1506 µs timeout in standard mode (big_mode_i=0) and 12 polls for 3000 µs in big mode. If status_n_i is still low at the last poll, the job ends with err_o=2.
- R6: Once a poll sees status_n_i high, byte_ready_o first rises after the setup delay: 2 µs in standard mode, 10 µs in big mode.
- R7: With swap_i=0, bit 0 of each byte is the first bit sent and bit 7 the last.
- R8: With swap_i=1, the byte is taken as pre-reversed: bit 7 is sent first and bit 0 last.
- R9: sck_o idles low and has a period of 2*SCK_HALF system clocks. sdo_o is set before each rising edge and held while sck_o is high.
- R10: If status_n_i is low after the byte marked byte_last_i has been sent, the job ends with err_o=3 and no trailing clocks are sent.
- R11: With done_present_i=1 and done_i low after the data phase, the job ends with err_o=4. With done_present_i=0, done_i is ignored.
- R12: After the completion checks pass, 8 more zero bits are clocked out. The job then ends with err_o=0.
- R13: busy_o is high from an accepted start until the job ends. end_o pulses for one cycle in the cycle busy_o falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a job (sampled in idle) |
| partial_i | input | 1 | Job is a partial reconfiguration (refused) |
| big_mode_i | input | 1 | Use the larger-device timing |
| swap_i | input | 1 | Bytes arrive pre-reversed; send bit 7 first |
| done_present_i | input | 1 | done_i is wired and is checked |
| byte_i | input | 8 | Bitstream byte |
| byte_valid_i | input | 1 | byte_i valid |
| byte_last_i | input | 1 | byte_i is the final bitstream byte |
| byte_ready_o | output | 1 | Block accepts byte_i this cycle |
| cfg_n_o | output | 1 | Configuration request to the target, active low |
| status_n_i | input | 1 | Target status, active low (low = in reset or error) |
| done_i | input | 1 | Target config-done |
| sck_o | output | 1 | Serial clock, idles low |
| sdo_o | output | 1 | Serial data |
| busy_o | output | 1 | Job in progress |
| end_o | output | 1 | One-cycle pulse when a job ends |
| err_o | output | 3 | 0 ok, 1 no reset, 2 not ready, 3 status error, 4 done inactive, 5 invalid request |

## Verification
Each timed result is counted from one register step to the next. Let C be the clocks per µs. The request pulse spans 2C+1 cycles. Each poll interval is 268C+1 cycles. byte_ready_o rises (268+setup)C+2 cycles after cfg_n_o rises, when the status line is released right away. A timeout ends the job 2C+1+N(268C+1) cycles after start. The bench samples on the falling clock edge, timestamps each event with a rising-edge counter, and compares each interval against a window of a few cycles around these values. Serial bits are captured on each rising sck_o edge and compared after end_o, once the stream is known to be complete.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;
  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_NO_RESET  = 3'd1,
    ERR_NOT_READY = 3'd2,
    ERR_STATUS    = 3'd3,
    ERR_DONE_LOW  = 3'd4,
    ERR_INVALID   = 3'd5
  } err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_POLL,
    ST_SETUP,
    ST_DATA,
    ST_DRAIN,
    ST_CHECK,
    ST_TRAIL
  } st_e;

  function automatic int ceil_div(int a, int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/ps_cfg_sync.sv
module ps_cfg_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ps_cfg_us_timer.sv
module ps_cfg_us_timer #(
  parameter int CLK_PER_US = 100,
  parameter int US_W       = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  output logic [US_W-1:0] us_o
);
  localparam int DIV_W = $clog2(CLK_PER_US + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);

  logic [DIV_W-1:0] div_q;
  logic [US_W-1:0]  us_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      us_q  <= '0;
    end else if (clr_i) begin
      div_q <= '0;
      us_q  <= '0;
    end else if (div_q == DIV_LAST) begin
      div_q <= '0;
      if (us_q != '1) us_q <= us_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign us_o = us_q;

  assert_us_monotonic_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clr_i) |-> us_q >= $past(us_q));
endmodule

// File: rtl/ps_cfg_shifter.sv
module ps_cfg_shifter #(
  parameter int SCK_HALF = 4,
  parameter int DW       = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          sck_o,
  output logic          sdo_o
);
  localparam int HC_W = $clog2(SCK_HALF + 1);
  localparam int BC_W = $clog2(DW);
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(SCK_HALF - 1);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(DW - 1);

  logic [DW-1:0]   sh_q;
  logic [HC_W-1:0] hc_q;
  logic [BC_W-1:0] bc_q;
  logic            sck_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      hc_q  <= '0;
      bc_q  <= '0;
      sck_q <= 1'b0;
      act_q <= 1'b0;
    end else if (load_i && !act_q) begin
      sh_q  <= data_i;
      hc_q  <= '0;
      bc_q  <= '0;
      sck_q <= 1'b0;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (hc_q == HC_LAST) begin
        hc_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
        end else begin
          sck_q <= 1'b0;
          if (bc_q == BC_LAST) begin
            act_q <= 1'b0;
          end else begin
            bc_q <= bc_q + 1'b1;
            sh_q <= {1'b0, sh_q[DW-1:1]};
          end
        end
      end else begin
        hc_q <= hc_q + 1'b1;
      end
    end
  end

  assign busy_o = act_q;
  assign sck_o  = sck_q;
  assign sdo_o  = act_q & sh_q[0];

  assert_sdo_stable_hi_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_q && $past(sck_q)) |-> $stable(sdo_o));
  assert_no_load_busy_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !act_q);
  assert_sck_idle_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q) |-> !sck_q);
endmodule

// File: rtl/ps_cfg_seq.sv
module ps_cfg_seq
  import ps_cfg_pkg::*;
#(
  parameter int CLK_PER_US     = 100,
  parameter int SCK_HALF       = 4,
  parameter int DW             = 8,
  parameter int T_PULSE_US     = 2,
  parameter int T_POLL_US      = 268,
  parameter int T_TMO_STD_US   = 1506,
  parameter int T_TMO_BIG_US   = 3000,
  parameter int T_SETUP_STD_US = 2,
  parameter int T_SETUP_BIG_US = 10,
  parameter int SYNC_STAGES    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          partial_i,
  input  logic          big_mode_i,
  input  logic          swap_i,
  input  logic          done_present_i,
  input  logic [DW-1:0] byte_i,
  input  logic          byte_valid_i,
  input  logic          byte_last_i,
  output logic          byte_ready_o,
  output logic          cfg_n_o,
  input  logic          status_n_i,
  input  logic          done_i,
  output logic          sck_o,
  output logic          sdo_o,
  output logic          busy_o,
  output logic          end_o,
  output logic [2:0]    err_o
);
  localparam int N_POLL_STD = ceil_div(T_TMO_STD_US, T_POLL_US);
  localparam int N_POLL_BIG = ceil_div(T_TMO_BIG_US, T_POLL_US);
  localparam int N_POLL_MAX = (N_POLL_BIG > N_POLL_STD) ? N_POLL_BIG : N_POLL_STD;
  localparam int POLL_W     = $clog2(N_POLL_MAX + 1);
  localparam int US_W       = $clog2(T_POLL_US + T_PULSE_US + T_SETUP_BIG_US + 2);
  localparam logic [US_W-1:0] LIM_PULSE = US_W'(T_PULSE_US);
  localparam logic [US_W-1:0] LIM_POLL  = US_W'(T_POLL_US);
  localparam logic [US_W-1:0] LIM_S_STD = US_W'(T_SETUP_STD_US);
  localparam logic [US_W-1:0] LIM_S_BIG = US_W'(T_SETUP_BIG_US);
  localparam logic [POLL_W-1:0] LAST_STD = POLL_W'(N_POLL_STD - 1);
  localparam logic [POLL_W-1:0] LAST_BIG = POLL_W'(N_POLL_BIG - 1);

  st_e               st_q, st_d;
  err_e              err_q, err_d;
  logic              big_q, big_d, swap_q, swap_d;
  logic              cfg_n_q, cfg_n_d, end_q, end_d;
  logic [POLL_W-1:0] poll_q, poll_d;

  logic              tmr_clr;
  logic [US_W-1:0]   us;
  logic              sh_load, sh_busy;
  logic [DW-1:0]     sh_data, byte_rev;
  logic [1:0]        sync_q;
  logic              stat_rel, done_s, accept;

  ps_cfg_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({done_i, status_n_i}),
    .q_o   (sync_q)
  );
  assign stat_rel = sync_q[0];
  assign done_s   = sync_q[1];

  ps_cfg_us_timer #(.CLK_PER_US(CLK_PER_US), .US_W(US_W)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .us_o  (us)
  );

  ps_cfg_shifter #(.SCK_HALF(SCK_HALF), .DW(DW)) u_shf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(sh_load),
    .data_i(sh_data),
    .busy_o(sh_busy),
    .sck_o (sck_o),
    .sdo_o (sdo_o)
  );

  for (genvar b = 0; b < DW; b++) begin : g_rev
    assign byte_rev[b] = byte_i[DW-1-b];
  end

  assign byte_ready_o = (st_q == ST_DATA) && !sh_busy;
  assign accept       = byte_ready_o && byte_valid_i;

  always_comb begin
    st_d    = st_q;
    err_d   = err_q;
    big_d   = big_q;
    swap_d  = swap_q;
    cfg_n_d = cfg_n_q;
    end_d   = 1'b0;
    poll_d  = poll_q;
    tmr_clr = 1'b0;
    sh_load = 1'b0;
    sh_data = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          end_d = partial_i;
          if (partial_i) begin
            err_d = ERR_INVALID;
          end else begin
            err_d   = ERR_NONE;
            big_d   = big_mode_i;
            swap_d  = swap_i;
            cfg_n_d = 1'b0;
            tmr_clr = 1'b1;
            st_d    = ST_PULSE;
          end
        end
      end
      ST_PULSE: begin
        if (us >= LIM_PULSE) begin
          cfg_n_d = 1'b1;
          tmr_clr = 1'b1;
          poll_d  = '0;
          if (!stat_rel) begin
            st_d = ST_POLL;
          end else begin
            st_d  = ST_IDLE;
            err_d = ERR_NO_RESET;
            end_d = 1'b1;
          end
        end
      end
      ST_POLL: begin
        if (us >= LIM_POLL) begin
          tmr_clr = 1'b1;
          if (stat_rel) begin
            st_d = ST_SETUP;
          end else if (poll_q == (big_q ? LAST_BIG : LAST_STD)) begin
            st_d  = ST_IDLE;
            err_d = ERR_NOT_READY;
            end_d = 1'b1;
          end else begin
            poll_d = poll_q + 1'b1;
          end
        end
      end
      ST_SETUP: begin
        if (us >= (big_q ? LIM_S_BIG : LIM_S_STD)) st_d = ST_DATA;
      end
      ST_DATA: begin
        if (accept) begin
          sh_load = 1'b1;
          sh_data = swap_q ? byte_rev : byte_i;
          if (byte_last_i) st_d = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (!sh_busy) st_d = ST_CHECK;
      end
      ST_CHECK: begin
        if (!stat_rel) begin
          st_d  = ST_IDLE;
          err_d = ERR_STATUS;
          end_d = 1'b1;
        end else if (done_present_i && !done_s) begin
          st_d  = ST_IDLE;
          err_d = ERR_DONE_LOW;
          end_d = 1'b1;
        end else begin
          sh_load = 1'b1;
          st_d    = ST_TRAIL;
        end
      end
      ST_TRAIL: begin
        if (!sh_busy) begin
          st_d  = ST_IDLE;
          end_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      err_q   <= ERR_NONE;
      big_q   <= 1'b0;
      swap_q  <= 1'b0;
      cfg_n_q <= 1'b1;
      end_q   <= 1'b0;
      poll_q  <= '0;
    end else begin
      st_q    <= st_d;
      err_q   <= err_d;
      big_q   <= big_d;
      swap_q  <= swap_d;
      cfg_n_q <= cfg_n_d;
      end_q   <= end_d;
      poll_q  <= poll_d;
    end
  end

  assign cfg_n_o = cfg_n_q;
  assign busy_o  = (st_q != ST_IDLE);
  assign end_o   = end_q;
  assign err_o   = err_q;

  assert_cfg_low_in_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_n_o |-> st_q == ST_PULSE);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_IDLE |-> cfg_n_o && !sck_o && !byte_ready_o);
  assert_end_clears_busy_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> !busy_o && $past(busy_o || start_i));
  assert_trail_ok_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TRAIL && !sh_busy) |=> end_o && err_o == 3'd0);
  assert_no_clk_before_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PULSE || st_q == ST_POLL || st_q == ST_SETUP) |-> !sck_o);
endmodule

// File: tb/sim_ps_cfg_seq.sv
`timescale 1ns/1ps
module sim_ps_cfg_seq;
  localparam int C    = 4;
  localparam int HALF = 2;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       start = 0, partial = 0, big = 0, swap = 0, dpres = 0;
  logic [7:0] bdat = 0;
  logic       bval = 0, blast = 0, stat_n = 1, done_in = 0;
  logic       bready, cfg_n, sck, sdo, busy, endp;
  logic [2:0] err;

  int nvec = 0, nmis = 0, cyc = 0, ncap = 0;
  logic cap [0:63];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge sck) begin
    if (ncap < 64) cap[ncap] = sdo;
    ncap = ncap + 1;
  end

  ps_cfg_seq #(.CLK_PER_US(C), .SCK_HALF(HALF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .partial_i(partial),
    .big_mode_i(big), .swap_i(swap), .done_present_i(dpres),
    .byte_i(bdat), .byte_valid_i(bval), .byte_last_i(blast),
    .byte_ready_o(bready), .cfg_n_o(cfg_n), .status_n_i(stat_n),
    .done_i(done_in), .sck_o(sck), .sdo_o(sdo), .busy_o(busy),
    .end_o(endp), .err_o(err)
  );

  task automatic check(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nmis++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic check_win(input string tag, input int act, input int lo, input int hi);
    nvec++;
    if (act < lo || act > hi) begin
      nmis++;
      $display("FAIL %s act=%0d exp=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wait_end();
    int g = 0;
    while (!endp && g < 40000) begin @(negedge clk); g++; end
  endtask

  task automatic kick(input bit p, input bit bg, input bit sw, input bit dp);
    @(negedge clk);
    start = 1; partial = p; big = bg; swap = sw; dpres = dp;
    @(negedge clk);
    start = 0; partial = 0;
  endtask

  task automatic t_reset();
    check("R1 cfg_n", cfg_n, 1);
    check("R1 sck", sck, 0);
    check("R1 busy", busy, 0);
    check("R1 ready", bready, 0);
    check("R1 end_err", {endp, err}, 0);
  endtask

  task automatic t_partial();
    ncap = 0;
    kick(1, 0, 0, 0);
    check("R2 end pulse", endp, 1);
    check("R2 err", err, 5);
    check("R2 busy", busy, 0);
    check("R2 cfg_n", cfg_n, 1);
    @(negedge clk);
    check("R2 end one cycle", endp, 0);
    check("R2 no clocks", ncap, 0);
  endtask

  task automatic t_no_reset();
    ncap = 0; stat_n = 1;
    kick(0, 0, 0, 0);
    wait_end();
    check("R4 err", err, 1);
    check("R4 cfg_n", cfg_n, 1);
    check("R4 no clocks", ncap, 0);
  endtask

  task automatic t_not_ready(input bit bg);
    int t0, np;
    ncap = 0;
    kick(0, bg, 0, 0);
    t0 = cyc; stat_n = 0;
    wait_end();
    np = bg ? 12 : 6;
    check_win(bg ? "R5 big timeout" : "R5 std timeout", cyc - t0,
              2*C + 1 + np*(268*C + 1) - 4, 2*C + 1 + np*(268*C + 1) + 4);
    check(bg ? "R5 big err" : "R5 std err", err, 2);
    check("R5 no clocks", ncap, 0);
    stat_n = 1;
  endtask

  task automatic run_job(input bit bg, input bit sw, input bit dp, input bit dv,
                         input bit fail_stat, input int nb,
                         input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                         input int exp_err, input string tag);
    int lowc = 0, tr, g = 0, nexp, bi, setup;
    logic [7:0] bv;
    ncap = 0; stat_n = 1; done_in = dv;
    kick(0, bg, sw, dp);
    check({tag, " R13 busy"}, busy, 1);
    stat_n = 0;
    while (!cfg_n && g < 1000) begin lowc++; @(negedge clk); g++; end
    check_win({tag, " R3 pulse"}, lowc, 2*C, 2*C + 2);
    tr = cyc; stat_n = 1;
    g = 0;
    while (!bready && g < 5000) begin @(negedge clk); g++; end
    setup = bg ? 10 : 2;
    check_win({tag, " R6 setup"}, cyc - tr, (268 + setup)*C, (268 + setup)*C + 4);
    for (int i = 0; i < nb; i++) begin
      bdat = (i == 0) ? b0 : (i == 1) ? b1 : b2;
      bval = 1; blast = (i == nb - 1);
      g = 0;
      while (!bready && g < 5000) begin @(negedge clk); g++; end
      @(negedge clk);
      bval = 0; blast = 0;
    end
    if (fail_stat) stat_n = 0;
    wait_end();
    check({tag, " err"}, err, exp_err);
    check({tag, " R13 busy low at end"}, busy, 0);
    nexp = nb*8 + ((exp_err == 0) ? 8 : 0);
    check({tag, " bit count"}, ncap, nexp);
    bi = 0;
    for (int i = 0; i < nb; i++) begin
      bv = (i == 0) ? b0 : (i == 1) ? b1 : b2;
      for (int k = 0; k < 8; k++) begin
        if (bi < 64 && bi < ncap)
          check(sw ? {tag, " R8 bit"} : {tag, " R7 bit"}, cap[bi], sw ? bv[7-k] : bv[k]);
        bi++;
      end
    end
    if (exp_err == 0)
      for (int k = 0; k < 8; k++) begin
        if (bi < ncap) check({tag, " R12 trail bit"}, cap[bi], 0);
        bi++;
      end
    stat_n = 1;
  endtask

  task automatic t_sck_period();
    int t1 = 0, t2 = 0, g = 0;
    ncap = 0; stat_n = 1; done_in = 1;
    kick(0, 0, 0, 0);
    stat_n = 0;
    while (!cfg_n && g < 1000) begin @(negedge clk); g++; end
    stat_n = 1;
    g = 0;
    while (!bready && g < 5000) begin @(negedge clk); g++; end
    check("R9 sck idle low before data", sck, 0);
    bdat = 8'h55; bval = 1; blast = 1;
    @(negedge clk);
    bval = 0; blast = 0;
    g = 0;
    while (!sck && g < 100) begin @(negedge clk); g++; end
    t1 = cyc;
    while (sck && g < 200) begin @(negedge clk); g++; end
    while (!sck && g < 300) begin @(negedge clk); g++; end
    t2 = cyc;
    check("R9 sck period", t2 - t1, 2*HALF);
    wait_end();
    check("R9 ok end", err, 0);
    check("R9 sck low after job", sck, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nmis++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_partial();
    t_no_reset();
    t_not_ready(0);
    t_not_ready(1);
    run_job(0, 0, 1, 1, 0, 3, 8'hA5, 8'h3C, 8'h01, 0, "R12 std ok");
    run_job(1, 1, 1, 1, 0, 2, 8'h80, 8'hF0, 8'h00, 0, "R8 big swap");
    run_job(0, 0, 1, 1, 1, 1, 8'hC3, 8'h00, 8'h00, 3, "R10 stat err");
    run_job(0, 1, 1, 0, 0, 1, 8'h96, 8'h00, 8'h00, 4, "R11 done low");
    run_job(0, 0, 0, 0, 0, 1, 8'h0F, 8'h00, 8'h00, 0, "R11 done absent");
    t_sck_period();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end
endmodule